// File: doc/BRIEF.md
# Bus Master Access Guard

This block sits between the bus masters of an interconnect and their targets. Each master has two attribute bits. The privilege bit selects privileged or unprivileged. The security bit selects Secure or Non-secure. For every request, the block compares these two bits with the attribute of the target address, which an address decoder outside this block supplies.

A permitted request is granted in the same cycle. A forbidden request gets a bus error response and never reaches its target. The first forbidden request is recorded: the block latches the master ID and the address, and raises a sticky fault flag. That record is held until software clears the flag through a write-one strobe. If the enable bit is set, the flag also drives an interrupt line.

Software sets the attributes through a small write port. The port selects one of three targets: the privilege bitmap, the security bitmap, or the interrupt enable.

Top module: `bmpu_guard`

## Requirements
- R1: After reset, every master is privileged and Secure, the fault flag is 0, the interrupt enable is 0, and the captured ID and address are 0.
- R2: A master whose security bit is 1 (Secure) is granted access to targets of either security attribute, provided the privilege rule in R4 allows it.
- R3: A master whose security bit is 0 (Non-secure) is denied when `tgt_ns` is 0 (Secure target) and is allowed when `tgt_ns` is 1.
- R4: A master whose privilege bit is 0 (unprivileged) is denied when `tgt_priv_only` is 1. A master whose privilege bit is 1 passes the privilege rule.
- R5: `grant` and `bus_err` are combinational in the request cycle and never both 1. Both are 0 when `req_valid` is 0. A denied request has `grant` at 0.
- R6: A denied request while the fault flag is 0 sets the flag at the next clock edge. At the same edge the request's ID goes to `fault_id` and its address goes to `fault_addr`.
- R7: While the flag is 1 and no clear is requested, later denials leave the flag, `fault_id` and `fault_addr` unchanged.
- R8: `flag_clr` = 1 clears the flag at the next edge. If a denial arrives in the same cycle as the clear, the flag stays 1 and the new ID and address are captured.
- R9: `irq` equals the fault flag ANDed with the interrupt enable.
- R10: When `cfg_we` = 1, the value of `cfg_sel` picks the target. 0 writes the privilege bitmap (bit i = 1 makes master i privileged). 1 writes the security bitmap (bit i = 1 makes master i Secure). 2 writes the interrupt enable from `cfg_wdata[0]`. 3 changes nothing. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | ID_W | Requesting master index |
| req_addr | input | ADDR_W | Request address |
| tgt_ns | input | 1 | Target address is Non-secure |
| tgt_priv_only | input | 1 | Target requires privileged access |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_sel | input | 2 | Write target select |
| cfg_wdata | input | NUM_MASTERS | Write data |
| flag_clr | input | 1 | Write-one clear of the fault flag |
| grant | output | 1 | Request may proceed to the target |
| bus_err | output | 1 | Request blocked with a bus error |
| fault_flag | output | 1 | Sticky security fault flag |
| irq | output | 1 | Interrupt request |
| fault_id | output | ID_W | Captured faulting master |
| fault_addr | output | ADDR_W | Captured faulting address |

## Verification
The bench walks every combination of the privilege bitmap and the security bitmap, every master, and both target attributes, and compares each decision with a formula. A design that swapped the sense of an attribute bit, or read the wrong master's bit, would grant forbidden accesses in this sweep. The bench also sends a second fault while the flag is set; a design that kept capturing would report the later master instead of the first. Two further cases catch mistakes in the clear logic. A clear that lands in the same cycle as a fault must not lose that fault. A write with the unused select must leave the attributes unchanged, so a design that decoded the select carelessly would show it.

// File: rtl/bmpu_guard_pkg.sv
package bmpu_guard_pkg;
  typedef enum logic [1:0] {
    SEL_PRIV = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/bmpu_attr_regs.sv
module bmpu_attr_regs #(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_sel,
  input  logic [NUM_MASTERS-1:0] cfg_wdata,
  output logic [NUM_MASTERS-1:0] priv_map,
  output logic [NUM_MASTERS-1:0] sec_map,
  output logic                   ien
);
  import bmpu_guard_pkg::*;

  logic [NUM_MASTERS-1:0] priv_d, sec_d;
  logic                   ien_d;
  cfg_sel_e               sel;

  assign sel = cfg_sel_e'(cfg_sel);

  always_comb begin
    priv_d = priv_map;
    sec_d  = sec_map;
    ien_d  = ien;
    if (cfg_we) begin
      case (sel)
        SEL_PRIV: priv_d = cfg_wdata;
        SEL_SEC:  sec_d  = cfg_wdata;
        SEL_IEN:  ien_d  = cfg_wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_map <= '1;
      sec_map  <= '1;
      ien      <= 1'b0;
    end else if (cfg_we) begin
      priv_map <= priv_d;
      sec_map  <= sec_d;
      ien      <= ien_d;
    end
  end
endmodule

// File: rtl/bmpu_access_judge.sv
module bmpu_access_judge #(
  parameter int NUM_MASTERS = 4,
  parameter int ID_W        = 2
) (
  input  logic                   req_valid,
  input  logic [ID_W-1:0]        req_id,
  input  logic                   tgt_ns,
  input  logic                   tgt_priv_only,
  input  logic [NUM_MASTERS-1:0] priv_map,
  input  logic [NUM_MASTERS-1:0] sec_map,
  output logic                   grant,
  output logic                   deny
);
  logic [NUM_MASTERS-1:0] allowed;
  logic                   sel_ok;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_master
    assign allowed[i] = (sec_map[i] | tgt_ns) & (priv_map[i] | ~tgt_priv_only);
  end

  always_comb begin
    sel_ok = 1'b0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (req_id == ID_W'(i)) sel_ok = allowed[i];
    end
  end

  assign grant = req_valid & sel_ok;
  assign deny  = req_valid & ~sel_ok;
endmodule

// File: rtl/bmpu_fault_capture.sv
module bmpu_fault_capture #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              flag_clr,
  input  logic              ien,
  output logic              fault_flag,
  output logic [ID_W-1:0]   fault_id,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              irq
);
  logic flag_d, cap_en;

  assign cap_en = deny & (~fault_flag | flag_clr);

  always_comb begin
    flag_d = (fault_flag & ~flag_clr) | deny;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_flag <= 1'b0;
    else        fault_flag <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_id   <= '0;
      fault_addr <= '0;
    end else if (cap_en) begin
      fault_id   <= req_id;
      fault_addr <= req_addr;
    end
  end

  assign irq = fault_flag & ien;
endmodule

// File: rtl/bmpu_guard.sv
module bmpu_guard #(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 16,
  localparam int ID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ID_W-1:0]        req_id,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   tgt_ns,
  input  logic                   tgt_priv_only,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_sel,
  input  logic [NUM_MASTERS-1:0] cfg_wdata,
  input  logic                   flag_clr,
  output logic                   grant,
  output logic                   bus_err,
  output logic                   fault_flag,
  output logic                   irq,
  output logic [ID_W-1:0]        fault_id,
  output logic [ADDR_W-1:0]      fault_addr
);
  logic [NUM_MASTERS-1:0] priv_map, sec_map;
  logic                   ien;

  bmpu_attr_regs #(.NUM_MASTERS(NUM_MASTERS)) u_attr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .priv_map(priv_map), .sec_map(sec_map), .ien(ien)
  );

  bmpu_access_judge #(.NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W)) u_judge (
    .req_valid(req_valid), .req_id(req_id), .tgt_ns(tgt_ns),
    .tgt_priv_only(tgt_priv_only), .priv_map(priv_map), .sec_map(sec_map),
    .grant(grant), .deny(bus_err)
  );

  bmpu_fault_capture #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_fault (
    .clk(clk), .rst_n(rst_n), .deny(bus_err), .req_id(req_id),
    .req_addr(req_addr), .flag_clr(flag_clr), .ien(ien),
    .fault_flag(fault_flag), .fault_id(fault_id), .fault_addr(fault_addr),
    .irq(irq)
  );
endmodule

// File: rtl/bmpu_guard_chk.sv
module bmpu_guard_chk #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ID_W-1:0]   req_id,
  input logic [ADDR_W-1:0] req_addr,
  input logic              flag_clr,
  input logic              grant,
  input logic              bus_err,
  input logic              fault_flag,
  input logic              irq,
  input logic [ID_W-1:0]   fault_id,
  input logic [ADDR_W-1:0] fault_addr
);
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && bus_err));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !bus_err));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !fault_flag) |=> (fault_flag && fault_id == $past(req_id)
                                  && fault_addr == $past(req_addr)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !flag_clr) |=> (fault_flag && $stable(fault_id) && $stable(fault_addr)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !bus_err) |=> !fault_flag);

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fault_flag);
endmodule

bind bmpu_guard bmpu_guard_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bmpu_guard_tb.sv
module bmpu_guard_tb;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, tgt_ns, tgt_priv_only, cfg_we, flag_clr;
  logic [IW-1:0] req_id;
  logic [AW-1:0] req_addr;
  logic [1:0] cfg_sel;
  logic [N-1:0] cfg_wdata;
  logic grant, bus_err, fault_flag, irq;
  logic [IW-1:0] fault_id;
  logic [AW-1:0] fault_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  bmpu_guard #(.NUM_MASTERS(N), .ADDR_W(AW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clr();
    @(negedge clk);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
  endtask

  // drive a request for one cycle; check grant/bus_err during it
  task automatic rq(input int id, input logic [AW-1:0] a, input logic ns, input logic po,
                    input logic exp_ok, input string req);
    @(negedge clk);
    req_valid = 1; req_id = IW'(id); req_addr = a; tgt_ns = ns; tgt_priv_only = po;
    #1;
    chk(req, {30'd0, grant, bus_err}, {30'd0, exp_ok, ~exp_ok});
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_id = 0; req_addr = 0; tgt_ns = 0; tgt_priv_only = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag", {31'd0, fault_flag}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 id", {30'd0, fault_id}, 0);
    chk("R1 addr", {16'd0, fault_addr}, 0);
    for (int id = 0; id < N; id++) begin
      rq(id, 16'h0100, 0, 1, 1, "R1 default priv+secure granted");
    end
    chk("R1 no fault", {31'd0, fault_flag}, 0);

    // R2 R3 R4 R5 exhaustive sweep over both bitmaps
    for (int p = 0; p < (1 << N); p++) begin
      wr(2'd0, N'(p));
      for (int s = 0; s < (1 << N); s++) begin
        wr(2'd1, N'(s));
        for (int id = 0; id < N; id++) begin
          for (int t = 0; t < 4; t++) begin
            logic ns, po, ok;
            ns = t[0]; po = t[1];
            ok = (s[id] | ns) & (p[id] | ~po);
            rq(id, AW'(t), ns, po, ok, "R2 R3 R4 R5 sweep");
          end
        end
      end
    end
    @(negedge clk);
    req_valid = 0; #1;
    chk("R5 idle", {30'd0, grant, bus_err}, 0);
    clr();
    chk("R8 cleared", {31'd0, fault_flag}, 0);

    // R10: master 2 Non-secure, master 1 unprivileged
    wr(2'd0, 4'b1101);
    wr(2'd1, 4'b1011);
    wr(2'd3, 4'b0000); // no effect
    rq(2, 16'h0000, 1, 0, 1, "R10 sel3 ignored ns");
    rq(0, 16'h0000, 0, 1, 1, "R10 sel3 ignored priv");
    chk("R10 no fault", {31'd0, fault_flag}, 0);

    // R6 capture
    wr(2'd2, 4'b0001);
    rq(2, 16'hBEEF, 0, 0, 0, "R3 ns master secure target");
    chk("R6 flag", {31'd0, fault_flag}, 1);
    chk("R6 id", {30'd0, fault_id}, 2);
    chk("R6 addr", {16'd0, fault_addr}, 16'hBEEF);
    chk("R9 irq on", {31'd0, irq}, 1);
    // R7 hold
    rq(1, 16'h1234, 1, 1, 0, "R4 unpriv master priv target");
    chk("R7 id held", {30'd0, fault_id}, 2);
    chk("R7 addr held", {16'd0, fault_addr}, 16'hBEEF);
    chk("R7 flag", {31'd0, fault_flag}, 1);
    // R9 enable off
    wr(2'd2, 4'b0000);
    chk("R9 irq off", {31'd0, irq}, 0);
    // R8 clear with simultaneous fault
    @(negedge clk);
    flag_clr = 1; req_valid = 1; req_id = 1; req_addr = 16'h5A5A; tgt_ns = 1; tgt_priv_only = 1;
    @(negedge clk);
    flag_clr = 0; req_valid = 0;
    chk("R8 flag kept", {31'd0, fault_flag}, 1);
    chk("R8 new id", {30'd0, fault_id}, 1);
    chk("R8 new addr", {16'd0, fault_addr}, 16'h5A5A);
    clr();
    chk("R8 clear", {31'd0, fault_flag}, 0);
    chk("R9 irq low", {31'd0, irq}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule